// File: doc/BRIEF.md
# Gated Store Buffer with Commit and Rollback

This block sits between a speculative execution core and a plain memory write port. Stores from a translated region enter through a valid/ready request interface and wait in the buffer in program order. Memory does not see any of them until the core raises a commit strobe. That strobe is issued in the same cycle as the matching register-file commit. From then on, the released entries drain to memory one per cycle, oldest first. A rollback strobe, issued together with the register-file rollback, erases every store that has not been committed. The speculative region therefore leaves memory exactly as it found it.

A load looks up the buffer combinationally. If one or more valid entries, committed or not, hold the load address, the youngest of them supplies the data. Otherwise the data presented by memory on the read port is passed through. The memory read address is the load address itself.

Top module: `gated_store_buffer`

## Requirements
- R1: After reset the buffer is empty: stReady is 1, memWrEn is 0 and ldHit is 0.
- R2: A store that has not been committed never causes a memory write. memWrEn is 0 in every cycle in which no committed entry is waiting.
- R3: A commit releases every store accepted before the commit cycle. From the cycle after the commit edge, these stores are written to memory one per cycle, oldest first, with the address and data they were accepted with.
- R4: A rollback discards every uncommitted entry, so those stores never reach memory. A store presented in the rollback cycle is dropped as well.
- R5: A store accepted in the same cycle as a commit belongs to the next region. It stays held, and a later rollback discards it.
- R6: Committed entries that have not yet drained survive a rollback and keep draining in order.
- R7: A load whose address matches one or more buffered entries gives ldHit = 1 and the data of the youngest matching entry. Committed and uncommitted entries both count.
- R8: A load that matches no buffered entry gives ldHit = 0, and ldData equals memRdData.
- R9: When DEPTH entries are held, stReady is 0 and a presented store is not accepted. stReady returns once an entry drains or a rollback frees space.
- R10: If commit and rollback are raised in the same cycle, the commit takes effect and the rollback is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| stValid | input | 1 | Store request valid |
| stReady | output | 1 | Buffer can accept a store this cycle |
| stAddr | input | AW | Store address |
| stData | input | DW | Store data |
| commit | input | 1 | Commit strobe for the current region |
| rollback | input | 1 | Rollback strobe for the current region |
| memWrEn | output | 1 | Memory write enable |
| memWrAddr | output | AW | Memory write address |
| memWrData | output | DW | Memory write data |
| ldAddr | input | AW | Load lookup address, also the memory read address |
| memRdData | input | DW | Memory read data for ldAddr |
| ldHit | output | 1 | Load matched a buffered entry |
| ldData | output | DW | Load result |

## Verification
stReady, ldHit and ldData are combinational functions of the inputs and the registered contents, so they are due in the same cycle as the stimulus. A store, commit or rollback changes the contents at the next rising edge. The first memory write of a committed region therefore appears in the cycle after the commit edge, and each later write follows one cycle after the one before. The bench drives inputs just after the falling edge and compares every output one time unit later, against a queue model that it advances only at the rising edge. Every expectation is thus taken in the cycle the result is due, and never before the edge that produces it.

// File: rtl/gsb_pkg.sv
package gsb_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic wrEn;    // capture the incoming store at wrIdx
    logic drainEn; // head entry is being written to memory
  } gsbStrobe_t;
endpackage

// File: rtl/gsb_ctrl.sv
module gsb_ctrl
  import gsb_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          stValid,
  output logic          stReady,
  input  logic          commit,
  input  logic          rollback,
  output gsbStrobe_t    strobe,
  output logic [IW-1:0] headIdx,
  output logic [IW-1:0] wrIdx,
  output logic [CW-1:0] occ
);
  // DEPTH is expected to be a power of two so indices wrap naturally
  logic [IW-1:0] headQ;
  logic [CW-1:0] totalQ, commitQ;
  logic [CW-1:0] totalD, commitD;
  logic [CW-1:0] totAfterDrain, comAfterDrain;
  logic          drain, accept, wrD;

  assign drain   = (commitQ != '0);
  assign stReady = (totalQ != CW'(DEPTH));
  assign accept  = stValid && stReady;

  assign totAfterDrain = totalQ - CW'(drain);
  assign comAfterDrain = commitQ - CW'(drain);

  always_comb begin
    totalD  = totAfterDrain + CW'(accept);
    commitD = comAfterDrain;
    wrD     = accept;
    if (commit) begin
      // everything already held becomes committed; new store opens next region
      commitD = totAfterDrain;
    end else if (rollback) begin
      totalD  = comAfterDrain;
      wrD     = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headQ   <= '0;
      totalQ  <= '0;
      commitQ <= '0;
    end else begin
      headQ   <= headQ + IW'(drain);
      totalQ  <= totalD;
      commitQ <= commitD;
    end
  end

  assign strobe.wrEn    = wrD;
  assign strobe.drainEn = drain;
  assign headIdx        = headQ;
  assign wrIdx          = headQ + IW'(totalQ);
  assign occ            = totalQ;

  // R2: without a pending commit and no commit strobe, no write starts
  assert_no_write_uncommitted_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.drainEn && !commit) |=> !strobe.drainEn);

  // R4: a rollback with nothing committed leaves memory idle afterwards
  assert_rollback_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rollback && !commit && !strobe.drainEn) |=> !strobe.drainEn);

  // R9: a full buffer that neither drains nor rolls back stays full
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!stReady && !strobe.drainEn && !rollback) |=> !stReady);

  // R10: commit wins over a simultaneous rollback
  assert_commit_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
    (commit && rollback && !strobe.drainEn && occ != '0) |=> strobe.drainEn);

  // R3: committed count never exceeds occupancy
  assert_commit_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    commitQ <= totalQ);
endmodule

// File: rtl/gsb_data.sv
module gsb_data
  import gsb_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW = 8,
  parameter int DW = 16,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  gsbStrobe_t    strobe,
  input  logic [IW-1:0] headIdx,
  input  logic [IW-1:0] wrIdx,
  input  logic [CW-1:0] occ,
  input  logic [AW-1:0] stAddr,
  input  logic [DW-1:0] stData,
  output logic [AW-1:0] memWrAddr,
  output logic [DW-1:0] memWrData,
  input  logic [AW-1:0] ldAddr,
  input  logic [DW-1:0] memRdData,
  output logic          ldHit,
  output logic [DW-1:0] ldData
);
  logic [AW-1:0] entAddr [DEPTH];
  logic [DW-1:0] entData [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : gEntry
    always_ff @(posedge clk) begin
      if (strobe.wrEn && wrIdx == IW'(g)) begin
        entAddr[g] <= stAddr;
        entData[g] <= stData;
      end
    end
  end

  assign memWrAddr = entAddr[headIdx];
  assign memWrData = entData[headIdx];

  // scan oldest to youngest; the last match wins
  always_comb begin
    ldHit  = 1'b0;
    ldData = memRdData;
    for (int age = 0; age < DEPTH; age++) begin
      if (CW'(age) < occ && entAddr[headIdx + IW'(age)] == ldAddr) begin
        ldHit  = 1'b1;
        ldData = entData[headIdx + IW'(age)];
      end
    end
  end

  // R8: an empty buffer can never hit
  assert_empty_miss_R8: assert property (@(posedge clk) disable iff (!rstN)
    (occ == '0) |-> !ldHit);
endmodule

// File: rtl/gated_store_buffer.sv
module gated_store_buffer
  import gsb_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          stValid,
  output logic          stReady,
  input  logic [AW-1:0] stAddr,
  input  logic [DW-1:0] stData,
  input  logic          commit,
  input  logic          rollback,
  output logic          memWrEn,
  output logic [AW-1:0] memWrAddr,
  output logic [DW-1:0] memWrData,
  input  logic [AW-1:0] ldAddr,
  input  logic [DW-1:0] memRdData,
  output logic          ldHit,
  output logic [DW-1:0] ldData
);
  localparam int IW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  gsbStrobe_t    strobe;
  logic [IW-1:0] headIdx, wrIdx;
  logic [CW-1:0] occ;

  gsb_ctrl #(.DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN), .stValid(stValid), .stReady(stReady),
    .commit(commit), .rollback(rollback), .strobe(strobe),
    .headIdx(headIdx), .wrIdx(wrIdx), .occ(occ)
  );

  gsb_data #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .headIdx(headIdx), .wrIdx(wrIdx),
    .occ(occ), .stAddr(stAddr), .stData(stData), .memWrAddr(memWrAddr),
    .memWrData(memWrData), .ldAddr(ldAddr), .memRdData(memRdData),
    .ldHit(ldHit), .ldData(ldData)
  );

  assign memWrEn = strobe.drainEn;
endmodule

// File: tb/sim_gated_store_buffer.sv
module sim_gated_store_buffer;
  localparam int DEPTH = 8;
  localparam int AW = 8;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          stValid = 1'b0, commit = 1'b0, rollback = 1'b0;
  logic [AW-1:0] stAddr = '0, ldAddr = '0;
  logic [DW-1:0] stData = '0;
  logic          stReady, memWrEn, ldHit;
  logic [AW-1:0] memWrAddr;
  logic [DW-1:0] memWrData, ldData, memRdData;

  logic [DW-1:0] mem [256];
  logic [AW-1:0] qa[$];
  logic [DW-1:0] qd[$];
  int mCom = 0;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  gated_store_buffer #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u0 (
    .clk(clk), .rstN(rstN), .stValid(stValid), .stReady(stReady),
    .stAddr(stAddr), .stData(stData), .commit(commit), .rollback(rollback),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData),
    .ldAddr(ldAddr), .memRdData(memRdData), .ldHit(ldHit), .ldData(ldData)
  );

  assign memRdData = mem[ldAddr];
  always @(posedge clk) if (memWrEn) mem[memWrAddr] <= memWrData;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // one cycle: drive after negedge, check, advance model at posedge
  task automatic step(input bit sv, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input bit cm, input bit rb, input logic [AW-1:0] la);
    bit acc, drn, expHit;
    logic [DW-1:0] expData;
    stValid = sv; stAddr = a; stData = d; commit = cm; rollback = rb; ldAddr = la;
    #1;
    chk(stReady === (qa.size() < DEPTH), "R9 stReady", 32'(stReady), 32'(qa.size() < DEPTH));
    chk(memWrEn === (mCom > 0), "R2 memWrEn", 32'(memWrEn), 32'(mCom > 0));
    if (mCom > 0) begin
      chk(memWrAddr === qa[0], "R3 drain addr", 32'(memWrAddr), 32'(qa[0]));
      chk(memWrData === qd[0], "R3 drain data", 32'(memWrData), 32'(qd[0]));
    end
    expHit = 1'b0;
    expData = mem[la];
    foreach (qa[i]) if (qa[i] == la) begin expHit = 1'b1; expData = qd[i]; end
    chk(ldHit === expHit, "R7 ldHit", 32'(ldHit), 32'(expHit));
    chk(ldData === expData, expHit ? "R7 ldData" : "R8 ldData", 32'(ldData), 32'(expData));
    acc = sv && (qa.size() < DEPTH);
    drn = (mCom > 0);
    @(posedge clk);
    if (drn) begin void'(qa.pop_front()); void'(qd.pop_front()); mCom--; end
    if (cm) begin
      mCom = qa.size();                      // R10: commit wins
      if (acc) begin qa.push_back(a); qd.push_back(d); end  // R5
    end else if (rb) begin
      while (qa.size() > mCom) begin void'(qa.pop_back()); void'(qd.pop_back()); end // R4 R6
    end else if (acc) begin
      qa.push_back(a); qd.push_back(d);
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 8'(i));
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'(i * 3 + 1);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    chk(stReady === 1'b1, "R1 stReady", 32'(stReady), 1);
    chk(memWrEn === 1'b0, "R1 memWrEn", 32'(memWrEn), 0);
    chk(ldHit === 1'b0, "R1 ldHit", 32'(ldHit), 0);
    @(negedge clk);
    // R2 R4: held stores, then rollback, memory untouched
    step(1, 8'h01, 16'hA001, 0, 0, 8'h01);
    step(1, 8'h02, 16'hA002, 0, 0, 8'h01);
    step(1, 8'h03, 16'hA003, 0, 1, 8'h02);
    idle(4);
    // R3 R7: same address twice, youngest returned, then commit drains in order
    step(1, 8'h05, 16'hB001, 0, 0, 8'h05);
    step(1, 8'h05, 16'hB002, 0, 0, 8'h05);
    step(1, 8'h06, 16'hB003, 0, 0, 8'h05);
    step(1, 8'h07, 16'hB004, 1, 0, 8'h07);  // R5: this store stays held
    step(0, 0, 0, 0, 0, 8'h05);
    step(0, 0, 0, 0, 1, 8'h07);             // R6: committed survive, R5 store dropped
    idle(5);
    // R9: fill to full, stall, then commit frees space
    for (int i = 0; i < DEPTH + 3; i++) step(1, 8'(8'h10 + i), 16'(16'hC000 + i), 0, 0, 8'h12);
    step(1, 8'h30, 16'hC0FF, 1, 0, 8'h10);
    idle(DEPTH + 2);
    // R10: commit and rollback together
    step(1, 8'h08, 16'hD001, 0, 0, 8'h08);
    step(1, 8'h09, 16'hD002, 1, 1, 8'h08);
    idle(4);
    // constrained random
    for (int n = 0; n < 4000; n++) begin
      automatic int r = $urandom_range(99);
      step(($urandom_range(99) < 60), 8'($urandom_range(15)), 16'($urandom),
           (r < 8), (r >= 8 && r < 13) || (r == 0 && $urandom_range(1) == 1),
           8'($urandom_range(15)));
    end
    step(0, 0, 0, 1, 0, 0);
    idle(DEPTH + 2);
    for (int i = 0; i < 16; i++) step(0, 0, 0, 0, 0, 8'(i));
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd12345));
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule